// File: doc/BRIEF.md
# Bus-Refreshed Watchdog Supervisor

This block is a watchdog timer that sits behind a simple processor register bus. Two control words are decoded outside the block: word offset 0 is the kick register and word offset 1 is the mode register. The block receives only the write strobes for those two offsets and bit 0 of the write data. Any write to the kick register restarts the timeout count. The mode bit chooses what keeps the timer alive: a free-running internal tick, or software kick writes.

If the timer runs to its terminal count, the block raises a global reset request for a fixed number of cycles and lights a fault indicator. The indicator stays lit until the next kick write. The global reset request is an output for the rest of the chip. It does not feed back into the block, so the fault indicator survives it.

The timeout length in cycles comes from a clock-frequency parameter and a timeout in milliseconds; the default is 1.6 s. A nonzero override parameter replaces the computed count so that simulation can use short windows.

Top module: `wdog_supervisor`

## Requirements
- R1: A pulse on `kick_we` restarts the timeout count from zero, in either refresh mode.
- R2: In software mode, if T clock edges pass after the last refresh edge with no refresh, `sys_rst_o` rises one cycle after the T-th edge. T is the timeout cycle count.
- R3: A pulse on `mode_we` loads `mode_wdata` (bit 0 of the bus data) as the refresh source, where 0 selects the internal tick and 1 selects software kicks. A mode write also restarts the count.
- R4: During and after `rst`, the mode is 0 (internal tick), and `sys_rst_o` and `fault_led_o` are 0.
- R5: While the internal tick is selected, no timeout ever occurs. The tick period is the timeout divided by `TICK_DIV`, and is at least 2 cycles.
- R6: Each timeout holds `sys_rst_o` high for exactly `PULSE_CYC` consecutive cycles.
- R7: A timeout sets `fault_led_o` in the same cycle that `sys_rst_o` rises. The next kick write clears it.
- R8: The block's own reset pulse does not clear the fault indicator. With no refresh, timeouts repeat every T edges.
- R9: A kick write in the cycle where the count is at its terminal value wins, and no reset is issued.
- R10: With `TIMEOUT_OVR` equal to 0, T equals `CLK_HZ * TIMEOUT_MS / 1000`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| kick_we | input | 1 | Write strobe for the kick register (word offset 0) |
| mode_we | input | 1 | Write strobe for the mode register (word offset 1) |
| mode_wdata | input | 1 | Bit 0 of the written data for the mode register |
| sys_rst_o | output | 1 | Global reset request pulse |
| fault_led_o | output | 1 | Fault indicator drive |

## Verification
The hardest case to reach from the ports is a kick that lands exactly in the terminal-count cycle. The stimulus gets there by writing software mode, which restarts the count, waiting exactly T-1 edges, and then kicking. The following window is then checked to end one cycle before a late expiry would have shown. After that refresh, the block is left idle until expiry, and the pulse is sampled on its first cycle, across its length and on the cycle after it ends. This pins down both the expiry edge and the pulse length. A second instance without the override confirms the count computed from the clock frequency.

// File: rtl/wdog_pkg.sv
package wdog_pkg;

  typedef enum logic {
    SRC_TICK = 1'b0,
    SRC_SW   = 1'b1
  } refresh_src_e;

  function automatic int unsigned timeout_cycles(input int unsigned hz,
                                                 input int unsigned ms,
                                                 input int unsigned ovr);
    longint unsigned prod;
    prod = (longint'(hz) * longint'(ms)) / 64'd1000;
    if (ovr != 0) return ovr;
    return int'(prod);
  endfunction

endpackage

// File: rtl/wdog_tick_gen.sv
module wdog_tick_gen #(
  parameter int unsigned TICK_CYC = 16
) (
  input  logic clk,
  input  logic rst,
  output logic tick_o
);
  localparam int TW = (TICK_CYC > 2) ? $clog2(TICK_CYC) : 1;

  logic [TW-1:0] tcnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      tcnt <= '0;
    end else if (tcnt == TW'(TICK_CYC - 1)) begin
      tcnt <= '0;
    end else begin
      tcnt <= tcnt + 1'b1;
    end
  end

  assign tick_o = (tcnt == TW'(TICK_CYC - 1));

endmodule

// File: rtl/wdog_timeout_ctr.sv
module wdog_timeout_ctr #(
  parameter int unsigned TIMEOUT_CYC = 64
) (
  input  logic clk,
  input  logic rst,
  input  logic refresh_i,
  output logic expire_o
);
  localparam int CW = $clog2(TIMEOUT_CYC);

  logic [CW-1:0] cnt;

  // Refresh is tested before the terminal compare, so a refresh in the
  // terminal cycle suppresses the expiry (R9).
  always_ff @(posedge clk) begin
    if (rst) begin
      cnt      <= '0;
      expire_o <= 1'b0;
    end else begin
      expire_o <= 1'b0;
      if (refresh_i) begin
        cnt <= '0;
      end else if (cnt == CW'(TIMEOUT_CYC - 1)) begin
        cnt      <= '0;
        expire_o <= 1'b1;
      end else begin
        cnt <= cnt + 1'b1;
      end
    end
  end

  // R9: refresh in any cycle, terminal included, blocks expiry next cycle
  a_r9_refresh_wins: assert property (@(posedge clk) disable iff (rst)
    refresh_i |=> !expire_o);

  // R8: timeouts are at least TIMEOUT_CYC apart, never back to back
  a_r8_single_expire: assert property (@(posedge clk) disable iff (rst)
    expire_o |=> !expire_o);

endmodule

// File: rtl/wdog_fault_out.sv
module wdog_fault_out #(
  parameter int unsigned PULSE_CYC = 16
) (
  input  logic clk,
  input  logic rst,
  input  logic expire_i,
  input  logic kick_i,
  output logic sys_rst_o,
  output logic fault_led_o
);
  localparam int PW = $clog2(PULSE_CYC + 1);

  logic [PW-1:0] pcnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      pcnt      <= '0;
      sys_rst_o <= 1'b0;
    end else if (expire_i) begin
      pcnt      <= PW'(PULSE_CYC - 1);
      sys_rst_o <= 1'b1;
    end else if (pcnt != '0) begin
      pcnt      <= pcnt - 1'b1;
      sys_rst_o <= 1'b1;
    end else begin
      sys_rst_o <= 1'b0;
    end
  end

  // A new timeout takes precedence over a coincident kick.
  always_ff @(posedge clk) begin
    if (rst)           fault_led_o <= 1'b0;
    else if (expire_i) fault_led_o <= 1'b1;
    else if (kick_i)   fault_led_o <= 1'b0;
  end

  // R6: pulse starts the cycle after the expiry strobe
  a_r6_pulse_start: assert property (@(posedge clk) disable iff (rst)
    expire_i |=> sys_rst_o);

  // R7: a kick without a fresh expiry turns the indicator off
  a_r7_kick_clears: assert property (@(posedge clk) disable iff (rst)
    (kick_i && !expire_i) |=> !fault_led_o);

  // R8: only a kick turns the indicator off, the reset pulse does not
  a_r8_fault_holds: assert property (@(posedge clk) disable iff (rst)
    (fault_led_o && !kick_i) |=> fault_led_o);

  // R7: the indicator is lit when the reset pulse begins
  a_r7_led_with_pulse: assert property (@(posedge clk) disable iff (rst)
    $rose(sys_rst_o) |-> fault_led_o);

endmodule

// File: rtl/wdog_supervisor.sv
module wdog_supervisor #(
  parameter int unsigned CLK_HZ      = 50_000_000,
  parameter int unsigned TIMEOUT_MS  = 1600,
  parameter int unsigned TIMEOUT_OVR = 0,
  parameter int unsigned TICK_DIV    = 16,
  parameter int unsigned PULSE_CYC   = 16
) (
  input  logic clk,
  input  logic rst,
  input  logic kick_we,
  input  logic mode_we,
  input  logic mode_wdata,
  output logic sys_rst_o,
  output logic fault_led_o
);
  import wdog_pkg::*;

  localparam int unsigned TIMEOUT_CYC = timeout_cycles(CLK_HZ, TIMEOUT_MS, TIMEOUT_OVR);
  localparam int unsigned TICK_RAW    = TIMEOUT_CYC / TICK_DIV;
  localparam int unsigned TICK_CYC    = (TICK_RAW < 2) ? 2 : TICK_RAW;

  refresh_src_e mode_q;
  logic         tick;
  logic         refresh;
  logic         expire;

  always_ff @(posedge clk) begin
    if (rst)          mode_q <= SRC_TICK;
    else if (mode_we) mode_q <= refresh_src_e'(mode_wdata);
  end

  wdog_tick_gen #(.TICK_CYC(TICK_CYC)) u_tick (
    .clk    (clk),
    .rst    (rst),
    .tick_o (tick)
  );

  // Kicks refresh in both modes; a mode write restarts the count so a
  // switch to the tick source can never inherit a nearly expired count.
  assign refresh = kick_we | mode_we | ((mode_q == SRC_TICK) & tick);

  wdog_timeout_ctr #(.TIMEOUT_CYC(TIMEOUT_CYC)) u_ctr (
    .clk       (clk),
    .rst       (rst),
    .refresh_i (refresh),
    .expire_o  (expire)
  );

  wdog_fault_out #(.PULSE_CYC(PULSE_CYC)) u_out (
    .clk         (clk),
    .rst         (rst),
    .expire_i    (expire),
    .kick_i      (kick_we),
    .sys_rst_o   (sys_rst_o),
    .fault_led_o (fault_led_o)
  );

  // R5: no timeout while the internal tick is the refresh source
  a_r5_tick_no_timeout: assert property (@(posedge clk) disable iff (rst)
    (mode_q == SRC_TICK) |-> !expire);

  // R4: reset leaves the tick source selected
  a_r4_reset_mode: assert property (@(posedge clk)
    rst |=> (mode_q == SRC_TICK));

  // R3: a mode write is seen in the next cycle
  a_r3_mode_load: assert property (@(posedge clk) disable iff (rst)
    mode_we |=> (mode_q == refresh_src_e'($past(mode_wdata))));

endmodule

// File: tb/wdog_supervisor_bench.sv
module wdog_supervisor_bench;

  localparam int unsigned T_OVR  = 40;
  localparam int unsigned PULSE  = 4;
  localparam int unsigned NVEC   = 12;

  // op codes: 0 none, 1 kick, 2 mode write 0, 3 mode write 1
  // vector = {op[1:0], wait[15:0], expect_pulse_seen, expect_led}
  localparam logic [19:0] VECS [0:NVEC-1] = '{
    {2'd0, 16'd200, 1'b0, 1'b0},  // R5 tick mode idle
    {2'd3, 16'd30,  1'b0, 1'b0},  // R3 enter software mode
    {2'd1, 16'd30,  1'b0, 1'b0},  // R1 kick restarts
    {2'd1, 16'd60,  1'b1, 1'b1},  // R2 timeout
    {2'd0, 16'd95,  1'b1, 1'b1},  // R8 repeated timeouts
    {2'd1, 16'd10,  1'b0, 1'b0},  // R7 kick clears led
    {2'd2, 16'd300, 1'b0, 1'b0},  // R5 back to tick mode
    {2'd3, 16'd39,  1'b0, 1'b0},  // R3 restart, count at terminal
    {2'd1, 16'd40,  1'b0, 1'b0},  // R9 kick at terminal wins
    {2'd0, 16'd1,   1'b1, 1'b1},  // R2 expiry edge exact
    {2'd0, 16'd3,   1'b1, 1'b1},  // R6 pulse continues
    {2'd0, 16'd1,   1'b0, 1'b1}   // R6 pulse ended, R8 led held
  };

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic kick_we = 1'b0, mode_we = 1'b0, mode_wdata = 1'b0;
  logic kick2 = 1'b0, mw2 = 1'b0, md2 = 1'b0;
  logic sys_rst_o, fault_led_o, rst2_o, led2_o;
  int   checks = 0;
  int   errors = 0;
  logic seen;

  always #10 clk = ~clk;

  wdog_supervisor #(.TIMEOUT_OVR(T_OVR), .PULSE_CYC(PULSE)) u_wdog_supervisor (
    .clk(clk), .rst(rst), .kick_we(kick_we), .mode_we(mode_we),
    .mode_wdata(mode_wdata), .sys_rst_o(sys_rst_o), .fault_led_o(fault_led_o)
  );

  // R10: 50 kHz with a 1 ms timeout gives a 50 cycle count
  wdog_supervisor #(.CLK_HZ(50_000), .TIMEOUT_MS(1), .PULSE_CYC(PULSE)) u_wdog_supervisor_derived (
    .clk(clk), .rst(rst), .kick_we(kick2), .mode_we(mw2),
    .mode_wdata(md2), .sys_rst_o(rst2_o), .fault_led_o(led2_o)
  );

  task automatic check(input string tag, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0b expected=%0b", tag, act, exp);
    end
  endtask

  task automatic do_op(input logic [1:0] op);
    if (op != 2'd0) begin
      kick_we    = (op == 2'd1);
      mode_we    = (op[1] == 1'b1);
      mode_wdata = (op == 2'd3);
      @(negedge clk);
      kick_we = 1'b0; mode_we = 1'b0; mode_wdata = 1'b0;
    end
  endtask

  task automatic wait_watch(input int n);
    seen = 1'b0;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if (sys_rst_o) seen = 1'b1;
    end
  endtask

  initial begin
    #(20 * 200000);
    errors++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R4 reset sys_rst", sys_rst_o, 1'b0);
    check("R4 reset led", fault_led_o, 1'b0);
    rst = 1'b0;
    @(negedge clk);

    // R10: derived count, software mode entered at edge E
    mw2 = 1'b1; md2 = 1'b1;
    @(negedge clk);
    mw2 = 1'b0; md2 = 1'b0;
    repeat (50) @(negedge clk);
    check("R10 no pulse at E+50", rst2_o, 1'b0);
    @(negedge clk);
    check("R10 pulse at E+51", rst2_o, 1'b1);
    check("R10 led at E+51", led2_o, 1'b1);

    for (int v = 0; v < NVEC; v++) begin
      do_op(VECS[v][19:18]);
      wait_watch(int'(VECS[v][17:2]));
      check($sformatf("vector %0d pulse seen", v), seen, VECS[v][1]);
      check($sformatf("vector %0d led", v), fault_led_o, VECS[v][0]);
    end

    // R4: reset while the led is lit returns to tick mode with outputs low
    rst = 1'b1;
    repeat (2) @(negedge clk);
    check("R4 mid reset led", fault_led_o, 1'b0);
    check("R4 mid reset sys_rst", sys_rst_o, 1'b0);
    rst = 1'b0;
    wait_watch(150);
    check("R4 tick mode after reset, no pulse", seen, 1'b0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule